// File: doc/BRIEF.md
# Switch MAC address table engine

This block is the forwarding database of an Ethernet switch. It holds entries keyed by a 48-bit MAC address and a 12-bit VLAN identifier, together with a destination port index and a 2-bit entry type. Software controls it through a small register file. It places the key in two 32-bit data words and then writes a command into the access register. The command field stays non-idle while the engine works and drops back to idle when the operation is finished, so software polls that field to know when the command has completed.

The table is set-associative: a row is chosen by XOR-folding the 60-bit key, and each row holds four entries (ways). Commands insert or refresh an entry, delete it, read back any row and way by index, or clear the whole table. A background scan ages dynamic entries on a programmable period counted in one-second ticks. Entries of the other three types stay until software removes them.

Top module: `mac_table_engine`

## Requirements
- R1: The key is written through two registers. At address 0 the word holds MAC bytes 2..5, with byte 2 most significant. At address 1, bits 27:16 hold the VID, bits 15:8 hold MAC byte 0 and bits 7:0 hold MAC byte 1. A READ returns a stored key in the same layout.
- R2: The access register is at address 2. Its bits 2:0 hold the command: 0 idle, 1 learn, 2 forget, 3 read, 4 init. A learn, forget or read shows its code for exactly one cycle after the write and then reads back as 0.
- R3: A write to the access register while the command field is not idle is ignored. Codes 5 to 7 are ignored as well.
- R4: The row is the XOR of key bit i into row bit (i mod ROW_BITS), where the key is {VID, MAC} and the VID sits in the top 12 bits. LEARN of a new key stores it as valid in the lowest-numbered free way of that row, with the type from access bits 4:3 and the destination from bits 10:5.
- R5: LEARN of a key already present updates its destination and type and clears its age mark, and creates no second copy.
- R6: LEARN into a row whose four ways hold other keys stores nothing and sets access bit 12 (table full). This bit stays set until an INIT completes or the block is reset.
- R7: FORGET invalidates the entry matching the key, whatever its type. A FORGET with no match changes nothing.
- R8: READ takes its way from bits 1:0 and its row from bits ROW_BITS+1:2 of the index register at address 3. It returns the valid flag in access bit 11, the destination, the type, the age mark in bit 13 and the key in the data registers.
- R9: INIT and reset clear one row per cycle. The command field reads 4 for 2^ROW_BITS cycles and then 0.
- R10: The age-period register at address 4 counts one-second tick pulses. When the count reaches the period, a scan visits every row. A type-0 entry is marked on its first scan and deleted on the next unless it was refreshed in between. A period of 0 stops aging.
- R11: Entries of type 1 (locked), 2 (IPv4 multicast) and 3 (IPv6 multicast) are never marked or deleted by aging.
- R12: The aging scan advances only while the command field is idle. Commands never wait for the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a table clear |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| sec_tick | input | 1 | One-cycle pulse per second for aging |

## Verification
The bench builds the engine with ROW_BITS = 6 and PER_W = 16. With 64 rows, a full clear and a full aging scan each last 64 cycles. That makes it cheap to run repeated clears and three back-to-back aging rounds with a period of two ticks, and to fill one row with keys whose folded hash collides. Every lookup is compared with a behavioural model that holds per-key destination, type and age mark, together with a row occupancy count that predicts the full flag.

// File: rtl/mact_pkg.sv
package mact_pkg;

    localparam int KEY_W  = 60;
    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int DEST_W = 6;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_LEARN  = 3'd1,
        CMD_FORGET = 3'd2,
        CMD_READ   = 3'd3,
        CMD_INIT   = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ET_NORMAL = 2'd0,
        ET_LOCKED = 2'd1,
        ET_MC4    = 2'd2,
        ET_MC6    = 2'd3
    } etype_e;

    localparam logic [2:0] A_KEYLO  = 3'd0;
    localparam logic [2:0] A_KEYHI  = 3'd1;
    localparam logic [2:0] A_ACCESS = 3'd2;
    localparam logic [2:0] A_INDEX  = 3'd3;
    localparam logic [2:0] A_AGECFG = 3'd4;

    typedef struct packed {
        logic              valid;
        logic              aged;
        etype_e            etype;
        logic [DEST_W-1:0] dest;
        logic [KEY_W-1:0]  key;
    } slot_t;

endpackage

// File: rtl/mact_row_hash.sv
module mact_row_hash
    import mact_pkg::*;
#(
    parameter int ROW_BITS = 10
) (
    input  logic [KEY_W-1:0]    key_i,
    output logic [ROW_BITS-1:0] row_o
);
    always_comb begin
        row_o = '0;
        for (int i = 0; i < KEY_W; i++) begin
            row_o[i % ROW_BITS] = row_o[i % ROW_BITS] ^ key_i[i];
        end
    end
endmodule

// File: rtl/mact_row_match.sv
module mact_row_match
    import mact_pkg::*;
(
    input  logic [WAYS-1:0]            vld_i,
    input  logic [WAYS-1:0][KEY_W-1:0] keys_i,
    input  logic [KEY_W-1:0]           key_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           hit_way_o,
    output logic                       free_o,
    output logic [WAY_W-1:0]           free_way_o
);
    logic [WAYS-1:0] hit_v;
    logic [WAYS-1:0] free_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign hit_v[w]  = vld_i[w] && (keys_i[w] == key_i);
        assign free_v[w] = !vld_i[w];
    end

    // lowest-numbered way wins
    always_comb begin
        hit_way_o  = '0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_v[w])  hit_way_o  = WAY_W'(w);
            if (free_v[w]) free_way_o = WAY_W'(w);
        end
    end

    assign hit_o  = |hit_v;
    assign free_o = |free_v;
endmodule

// File: rtl/mact_age_sched.sv
module mact_age_sched #(
    parameter int ROW_BITS = 10,
    parameter int PER_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [PER_W-1:0]    period_i,
    input  logic                go_i,
    input  logic                kill_i,
    output logic                step_o,
    output logic [ROW_BITS-1:0] row_o
);
    logic [PER_W-1:0]    cnt_q;
    logic [PER_W:0]      cnt_nxt;
    logic                act_q;
    logic [ROW_BITS-1:0] row_q;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
    assign step_o  = act_q && go_i;
    assign row_o   = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
            row_q <= '0;
        end else begin
            if (kill_i) begin
                act_q <= 1'b0;
                row_q <= '0;
            end else if (step_o) begin
                row_q <= row_q + 1'b1;
                if (row_q == '1) act_q <= 1'b0;
            end
            if (tick_i && (period_i != '0)) begin
                if (cnt_nxt >= {1'b0, period_i}) begin
                    cnt_q <= '0;
                    if (!kill_i) act_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_nxt[PER_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine
    import mact_pkg::*;
#(
    parameter int ROW_BITS = 10,
    parameter int PER_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data,
    input  logic        sec_tick
);
    localparam int ROWS = 1 << ROW_BITS;

    slot_t [WAYS-1:0] tbl [ROWS];

    logic [KEY_W-1:0]    key_q;
    etype_e              etype_q;
    logic [DEST_W-1:0]   dest_q;
    logic                valid_q;
    logic                aged_q;
    cmd_e                cmd_q;
    logic                full_q;
    logic [ROW_BITS-1:0] idx_row;
    logic [WAY_W-1:0]    idx_way;
    logic [PER_W-1:0]    period_q;
    logic [ROW_BITS-1:0] init_row;

    logic [ROW_BITS-1:0] hash_row;
    logic [ROW_BITS-1:0] op_row;
    slot_t [WAYS-1:0]    cur;
    logic [WAYS-1:0]            cur_vld;
    logic [WAYS-1:0][KEY_W-1:0] cur_keys;
    logic                m_hit, m_free;
    logic [WAY_W-1:0]    m_hit_way, m_free_way;
    logic                sweep_step;
    logic [ROW_BITS-1:0] sweep_row;

    mact_row_hash #(.ROW_BITS(ROW_BITS)) u_hash (
        .key_i (key_q),
        .row_o (hash_row)
    );

    assign op_row = (cmd_q == CMD_READ) ? idx_row : hash_row;
    assign cur    = tbl[op_row];

    for (genvar w = 0; w < WAYS; w++) begin : g_unpack
        assign cur_vld[w]  = cur[w].valid;
        assign cur_keys[w] = cur[w].key;
    end

    mact_row_match u_match (
        .vld_i      (cur_vld),
        .keys_i     (cur_keys),
        .key_i      (key_q),
        .hit_o      (m_hit),
        .hit_way_o  (m_hit_way),
        .free_o     (m_free),
        .free_way_o (m_free_way)
    );

    mact_age_sched #(.ROW_BITS(ROW_BITS), .PER_W(PER_W)) u_age (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (sec_tick),
        .period_i (period_q),
        .go_i     (cmd_q == CMD_IDLE),
        .kill_i   (cmd_q == CMD_INIT),
        .step_o   (sweep_step),
        .row_o    (sweep_row)
    );

    // table storage: commands first, aging scan only when idle
    always_ff @(posedge clk) begin
        if (cmd_q == CMD_INIT) begin
            for (int w = 0; w < WAYS; w++) begin
                tbl[init_row][w].valid <= 1'b0;
                tbl[init_row][w].aged  <= 1'b0;
            end
        end else if (cmd_q == CMD_LEARN) begin
            if (m_hit) begin
                tbl[op_row][m_hit_way].etype <= etype_q;
                tbl[op_row][m_hit_way].dest  <= dest_q;
                tbl[op_row][m_hit_way].aged  <= 1'b0;
            end else if (m_free) begin
                tbl[op_row][m_free_way] <= '{valid: 1'b1, aged: 1'b0,
                                             etype: etype_q, dest: dest_q,
                                             key: key_q};
            end
        end else if (cmd_q == CMD_FORGET) begin
            if (m_hit) tbl[op_row][m_hit_way].valid <= 1'b0;
        end else if (sweep_step) begin
            for (int w = 0; w < WAYS; w++) begin
                if (tbl[sweep_row][w].valid && (tbl[sweep_row][w].etype == ET_NORMAL)) begin
                    if (tbl[sweep_row][w].aged) tbl[sweep_row][w].valid <= 1'b0;
                    else                        tbl[sweep_row][w].aged  <= 1'b1;
                end
            end
        end
    end

    // register file and command sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q    <= '0;
            etype_q  <= ET_NORMAL;
            dest_q   <= '0;
            valid_q  <= 1'b0;
            aged_q   <= 1'b0;
            cmd_q    <= CMD_INIT;
            full_q   <= 1'b0;
            idx_row  <= '0;
            idx_way  <= '0;
            period_q <= '0;
            init_row <= '0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_KEYLO:  key_q[31:0]  <= wr_data;
                    A_KEYHI:  key_q[59:32] <= {wr_data[27:16], wr_data[15:0]};
                    A_ACCESS: if (cmd_q == CMD_IDLE && wr_data[2:0] <= 3'd4) begin
                        cmd_q    <= cmd_e'(wr_data[2:0]);
                        etype_q  <= etype_e'(wr_data[4:3]);
                        dest_q   <= wr_data[10:5];
                        init_row <= '0;
                    end
                    A_INDEX: begin
                        idx_way <= wr_data[1:0];
                        idx_row <= wr_data[ROW_BITS+1:2];
                    end
                    A_AGECFG: period_q <= wr_data[PER_W-1:0];
                    default: ;
                endcase
            end
            case (cmd_q)
                CMD_LEARN: begin
                    if (!m_hit && !m_free) full_q <= 1'b1;
                    cmd_q <= CMD_IDLE;
                end
                CMD_FORGET: cmd_q <= CMD_IDLE;
                CMD_READ: begin
                    key_q   <= cur[idx_way].key;
                    valid_q <= cur[idx_way].valid;
                    aged_q  <= cur[idx_way].aged;
                    etype_q <= cur[idx_way].etype;
                    dest_q  <= cur[idx_way].dest;
                    cmd_q   <= CMD_IDLE;
                end
                CMD_INIT: begin
                    init_row <= init_row + 1'b1;
                    if (init_row == '1) begin
                        cmd_q  <= CMD_IDLE;
                        full_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_KEYLO:  rd_data = key_q[31:0];
            A_KEYHI:  rd_data = {4'b0, key_q[59:48], key_q[47:32]};
            A_ACCESS: rd_data = {18'b0, aged_q, full_q, valid_q, dest_q, etype_q, cmd_q};
            A_INDEX:  rd_data = 32'({idx_row, idx_way});
            A_AGECFG: rd_data = 32'(period_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/mact_checker.sv
module mact_checker #(
    parameter int ROW_BITS = 10
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          cmd_i,
    input logic                full_i,
    input logic [ROW_BITS-1:0] init_row_i,
    input logic                step_i,
    input logic [ROW_BITS-1:0] sweep_row_i
);
    assert_cmd_done_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd1 || cmd_i == 3'd2 || cmd_i == 3'd3) |=> (cmd_i == 3'd0));

    assert_init_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd4 && init_row_i != '1) |=> (cmd_i == 3'd4));

    assert_init_end_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd4 && init_row_i == '1) |=> (cmd_i == 3'd0 && !full_i));

    assert_full_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (full_i && cmd_i != 3'd4) |=> full_i);

    assert_sweep_yield_R12: assert property (@(posedge clk) disable iff (rst)
        step_i |-> (cmd_i == 3'd0));

    assert_sweep_walk_R10: assert property (@(posedge clk) disable iff (rst)
        step_i |=> (sweep_row_i == ROW_BITS'($past(sweep_row_i) + 1'b1)));
endmodule

bind mac_table_engine mact_checker #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_i       (cmd_q),
    .full_i      (full_q),
    .init_row_i  (init_row),
    .step_i      (sweep_step),
    .sweep_row_i (sweep_row)
);

// File: tb/sim_mac_table_engine.sv
module sim_mac_table_engine;
    import mact_pkg::*;

    localparam int RB    = 6;
    localparam int NROWS = 1 << RB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sec_tick = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { int dest; int et; bit aged; } ent_t;
    ent_t mdl [logic [59:0]];
    bit   full_exp = 0;
    int   period = 0;
    int   tcnt = 0;

    mac_table_engine #(.ROW_BITS(RB), .PER_W(16)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_tick(sec_tick)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [RB-1:0] ref_hash(input logic [59:0] k);
        logic [RB-1:0] h = '0;
        for (int i = 0; i < 60; i++) h[i % RB] = h[i % RB] ^ k[i];
        return h;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_key(input logic [59:0] k);
        wr(A_KEYLO, k[31:0]);
        wr(A_KEYHI, {4'b0, k[59:48], k[47:32]});
    endtask

    task automatic issue(input logic [2:0] cmd, input int et, input int dest, input string req);
        logic [31:0] v;
        wr(A_ACCESS, {21'b0, 6'(dest), 2'(et), cmd});
        rd(A_ACCESS, v);
        check(v[2:0] == cmd, {req, " R2 busy code"}, 64'(v[2:0]), 64'(cmd));
        @(negedge clk);
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd0, {req, " R2 back to idle"}, 64'(v[2:0]), 64'd0);
    endtask

    task automatic lookup(input logic [59:0] key, output bit found, output int way,
                          output int dest, output int et, output bit aged,
                          output int cnt, output logic [31:0] hi);
        logic [RB-1:0] row;
        logic [31:0]   h, lo, acc;
        row = ref_hash(key);
        found = 0; way = -1; dest = 0; et = 0; aged = 0; cnt = 0; hi = '0;
        for (int w = 0; w < 4; w++) begin
            wr(A_INDEX, 32'({row, 2'(w)}));
            issue(CMD_READ, 0, 0, "R8 read");
            rd(A_KEYHI, h);
            rd(A_KEYLO, lo);
            rd(A_ACCESS, acc);
            if (acc[11] && ({h[27:16], h[15:0], lo} == key)) begin
                cnt++;
                if (!found) begin
                    found = 1; way = w; dest = int'(acc[10:5]);
                    et = int'(acc[4:3]); aged = acc[13]; hi = h;
                end
            end
        end
    endtask

    task automatic verify(input logic [59:0] key, input string req);
        bit found, aged;
        int way, dest, et, cnt;
        logic [31:0] hi;
        bit exp;
        lookup(key, found, way, dest, et, aged, cnt, hi);
        exp = mdl.exists(key);
        check(found == exp, {req, " presence"}, 64'(found), 64'(exp));
        check(cnt <= 1, "R5 single copy", 64'(cnt), 64'd1);
        if (exp && found) begin
            check(dest == mdl[key].dest, {req, " dest"}, 64'(dest), 64'(mdl[key].dest));
            check(et == mdl[key].et, {req, " type"}, 64'(et), 64'(mdl[key].et));
            check(aged == mdl[key].aged, {req, " age mark"}, 64'(aged), 64'(mdl[key].aged));
        end
    endtask

    task automatic expect_way(input logic [59:0] key, input int exp_way, input string req);
        bit found, aged;
        int way, dest, et, cnt;
        logic [31:0] hi;
        lookup(key, found, way, dest, et, aged, cnt, hi);
        check(way == exp_way, req, 64'(way), 64'(exp_way));
    endtask

    task automatic learn(input logic [59:0] key, input int et, input int dest, input string req);
        int n = 0;
        logic [31:0] acc;
        set_key(key);
        issue(CMD_LEARN, et, dest, req);
        if (mdl.exists(key)) begin
            mdl[key].dest = dest; mdl[key].et = et; mdl[key].aged = 0;
        end else begin
            foreach (mdl[k]) if (ref_hash(k) == ref_hash(key)) n++;
            if (n < 4) mdl[key] = '{dest, et, 1'b0};
            else full_exp = 1;
        end
        rd(A_ACCESS, acc);
        check(acc[12] == full_exp, {req, " R6 full flag"}, 64'(acc[12]), 64'(full_exp));
    endtask

    task automatic forget(input logic [59:0] key, input string req);
        set_key(key);
        issue(CMD_FORGET, 0, 0, req);
        if (mdl.exists(key)) mdl.delete(key);
    endtask

    task automatic do_init(input string req);
        logic [31:0] v;
        wr(A_ACCESS, {29'b0, CMD_INIT});
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd4, {req, " R9 init busy"}, 64'(v[2:0]), 64'd4);
        repeat (NROWS - 1) @(negedge clk);
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd4, {req, " R9 init still busy"}, 64'(v[2:0]), 64'd4);
        @(negedge clk);
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd0 && v[12] == 1'b0, {req, " R9 init done, R6 full cleared"},
              64'(v[12:0]), 64'd0);
        mdl.delete();
        full_exp = 0;
    endtask

    task automatic model_sweep();
        logic [59:0] gone[$];
        foreach (mdl[k]) begin
            if (mdl[k].et == 0) begin
                if (mdl[k].aged) gone.push_back(k);
                else mdl[k].aged = 1;
            end
        end
        foreach (gone[i]) mdl.delete(gone[i]);
    endtask

    task automatic tick(input bit wait_done);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        if (period != 0) begin
            tcnt++;
            if (tcnt >= period) begin
                tcnt = 0;
                model_sweep();
            end
        end
        if (wait_done) repeat (NROWS + 4) @(negedge clk);
    endtask

    function automatic logic [59:0] kcol(input int k);
        return {12'h00A, 36'h123456789, 6'(k), 6'(k)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [59:0] ka, kn, kn2, kl, km, km6, kn3, kp;
        bit found, aged;
        int way, dest, et, cnt;
        logic [31:0] hi;

        ka  = {12'h005, 48'h0011_2233_4455};
        kn  = {12'h001, 48'h0200_0000_0101};
        kn2 = {12'h002, 48'h0200_0000_0202};
        kl  = {12'h003, 48'h0200_0000_0303};
        km  = {12'h004, 48'h0000_0300_0000};
        km6 = {12'h007, 48'h0000_0C00_0000};
        kn3 = {12'h009, 48'h0200_0000_0909};
        kp  = {12'h00B, 48'h0200_0000_0B0B};

        // reset state: clearing runs, then idle (R9)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd4, "R9 reset starts clear", 64'(v[2:0]), 64'd4);
        repeat (NROWS) @(negedge clk);
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd0 && v[12] == 1'b0, "R9 reset clear done", 64'(v[12:0]), 64'd0);

        // R1 R4 R8: learn and read back
        learn(ka, 0, 3, "R4 learn new");
        verify(ka, "R4 R8 readback");
        lookup(ka, found, way, dest, et, aged, cnt, hi);
        check(hi == {4'h0, 12'h005, 8'h00, 8'h11}, "R1 high word layout", 64'(hi),
              64'({4'h0, 12'h005, 8'h00, 8'h11}));

        // R5 refresh existing key
        learn(ka, 1, 5, "R5 relearn");
        verify(ka, "R5 updated");
        lookup(ka, found, way, dest, et, aged, cnt, hi);
        check(cnt == 1, "R5 no duplicate", 64'(cnt), 64'd1);

        do_init("R9 clear");
        verify(ka, "R9 cleared entry");

        // R4 R6: fill one row
        for (int k = 1; k <= 4; k++) learn(kcol(k), 0, k, "R4 fill row");
        expect_way(kcol(1), 0, "R4 lowest way first");
        expect_way(kcol(4), 3, "R4 last way");
        learn(kcol(5), 0, 5, "R6 row full");
        verify(kcol(5), "R6 not stored");

        // R7 forget
        forget(kcol(2), "R7 forget");
        verify(kcol(2), "R7 removed");
        verify(kcol(1), "R7 neighbour kept");
        forget(kcol(2), "R7 forget absent");
        verify(kcol(3), "R7 no-match no effect");
        verify(kcol(4), "R7 no-match no effect");
        rd(A_ACCESS, v);
        check(v[12] == 1'b1, "R6 full sticky", 64'(v[12]), 64'd1);

        learn(kcol(5), 0, 5, "R4 reuse freed way");
        expect_way(kcol(5), 1, "R4 freed way reused");

        // R3 write while busy ignored
        set_key(kcol(3));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_ACCESS; wr_data = {21'b0, 6'd9, 2'd0, CMD_LEARN};
        @(negedge clk);
        wr_data = {21'b0, 6'd0, 2'd0, CMD_FORGET};
        @(negedge clk);
        wr_en = 1'b0;
        mdl[kcol(3)].dest = 9;
        verify(kcol(3), "R3 busy write ignored");
        // R3 undefined code ignored
        wr(A_ACCESS, 32'd7);
        rd(A_ACCESS, v);
        check(v[2:0] == 3'd0, "R3 undefined code ignored", 64'(v[2:0]), 64'd0);

        do_init("R6 R9 clear");

        // R10 R11 R12 aging, period of two ticks
        period = 2; tcnt = 0;
        wr(A_AGECFG, 32'd2);
        learn(kn, 0, 1, "R10 learn");
        learn(kn2, 0, 2, "R10 learn");
        learn(kl, 1, 3, "R11 learn locked");
        learn(km, 2, 4, "R11 learn mc4");
        learn(km6, 3, 5, "R11 learn mc6");
        tick(1);
        verify(kn, "R10 one tick no scan");
        tick(0);
        set_key(kn3);
        issue(CMD_LEARN, 1, 7, "R12 command during scan");
        repeat (NROWS + 4) @(negedge clk);
        lookup(kn3, found, way, dest, et, aged, cnt, hi);
        check(found && dest == 7, "R12 learn during scan", 64'(dest), 64'd7);
        forget(kn3, "R12 cleanup");
        verify(kn, "R10 first scan marks");
        verify(kl, "R11 locked unmarked");
        learn(kn2, 0, 2, "R5 refresh clears mark");
        verify(kn2, "R5 mark cleared");
        tick(1); tick(1);
        verify(kn, "R10 second scan deletes");
        verify(kn2, "R10 refreshed survives");
        verify(kl, "R11 locked kept");
        verify(km, "R11 mc4 kept");
        verify(km6, "R11 mc6 kept");
        tick(1); tick(1);
        verify(kn2, "R10 deleted after two scans");
        verify(km, "R11 mc4 kept");

        // R10 period zero stops aging
        period = 0;
        wr(A_AGECFG, 32'd0);
        learn(kp, 0, 6, "R10 learn");
        repeat (4) tick(1);
        verify(kp, "R10 period zero");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule